// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one request for a processor. Each line is fixed at build time as edge-sensitive, where a rising transition is caught, or level-sensitive, where the line is sampled every cycle while it is high. Caught requests are held in a status word. An enable word masks them, and the masked result is the pending word. Software reads a vector register to learn which pending line comes first. Software clears lines by writing ones to an acknowledge register. Enable bits can be changed in place through separate set and clear registers, so no read-modify-write is needed.

The register interface is a 32-bit word bus with a one-cycle strobe. A write takes effect on the clock edge where the strobe and write are both high. A read returns data combinationally while the strobe is high and write is low.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and the control bits read as zero, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: A write to byte offset 0x08 replaces the enable word with the written value. Writing 0 disables every input.
- R3: A write to offset 0x10 sets each enable bit written as 1. Every other enable bit keeps its value.
- R4: A write to offset 0x14 clears each enable bit written as 1. Every other enable bit keeps its value.
- R5: A write to offset 0x0C clears each status bit written as 1, unless its source requests again in that cycle. Writing 0xFFFFFFFF clears all latched edge requests.
- R6: Offset 0x18 reads the index of the lowest-numbered pending input. It reads 0xFFFFFFFF when nothing is pending.
- R7: Offset 0x00 reads the status word. Offset 0x04 reads status AND enable. Disabling an input hides it from the pending word but does not clear its status bit.
- R8: `irq_out` is high exactly when bit 0 (run) of offset 0x1C is 1 and at least one pending bit is set. It rises in the cycle after the request is captured.
- R9: An input whose kind bit is 1 (edge) sets its status bit once on a 0-to-1 transition. Once acknowledged, the bit stays clear while the input is held high.
- R10: An input whose kind bit is 0 (level) sets its status bit on every cycle it is high. An acknowledge therefore does not clear the bit while the input is still asserted.
- R11: While bit 1 (hardware-lock) of offset 0x1C is 0, a write to offset 0x00 sets the status bits written as 1. Once bit 1 is written as 1, such writes have no effect and bit 1 reads 1 until reset, even after 0 is written to it.
- R12: Enable and status bits at or above the number of inputs do not exist and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus strobe for one access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while a read is strobed |
| src_in | input | NUM_SRC | Interrupt source lines |
| irq_out | output | 1 | Request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands while a source is still driving. The outcome depends on the input kind. A held level line must survive the acknowledge, while a held edge line must stay cleared. The stimulus raises one level line and one edge line together and keeps both high across an all-ones acknowledge. It then reads the status word to see which bit returned. A second hard case is the sticky lock bit. The bench reaches it by triggering a software interrupt first, then setting the lock and trying the same write again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Register select: word index taken from byte address bits 4:2
   typedef enum logic [2:0] {
      RS_STATUS = 3'd0,
      RS_PEND   = 3'd1,
      RS_ENABLE = 3'd2,
      RS_ACK    = 3'd3,
      RS_SETEN  = 3'd4,
      RS_CLREN  = 3'd5,
      RS_VECTOR = 3'd6,
      RS_CTRL   = 3'd7
   } reg_sel_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_LOCK_BIT = 1;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
   parameter int          NUM_SRC    = 8,
   parameter logic [31:0] EDGE_KINDS = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [NUM_SRC-1:0] hit
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (EDGE_KINDS[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_in[i];
         end
         assign hit[i] = src_in[i] & ~prev_q;
      end else begin : g_level
         assign hit[i] = src_in[i];
      end
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               valid,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC    = 8,
   parameter logic [31:0] EDGE_KINDS = 32'h0000_00F0,
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_out
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_num
      $error("NUM_SRC must lie in 1..32");
   end
   if (DATA_W < NUM_SRC || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must cover every source");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end
   if (NUM_SRC < 32) begin : g_kind_chk
      if ((EDGE_KINDS >> NUM_SRC) != 32'h0) begin : g_bad_kind
         $error("EDGE_KINDS has bits above NUM_SRC");
      end
   end

   reg_sel_e           word;
   logic               wr_go;
   logic [NUM_SRC-1:0] wmask;
   logic [NUM_SRC-1:0] status, enable, pend, hit;
   logic               run_q, lock_q;
   logic               vec_valid;
   logic [IDX_W-1:0]   vec_idx;
   logic [DATA_W-1:0]  stat_w, pend_w, en_w, vec_w, ctrl_w;
   logic               unused_bus;

   assign word       = reg_sel_e'(bus_addr[4:2]);
   assign wr_go      = bus_sel & bus_wr;
   assign wmask      = bus_wdata[NUM_SRC-1:0];
   assign unused_bus = ^{bus_wdata, bus_addr};

   irqc_detect #(.NUM_SRC(NUM_SRC), .EDGE_KINDS(EDGE_KINDS)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .src_in(src_in),
      .hit   (hit)
   );

   // status: new requests win over an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         logic [NUM_SRC-1:0] clr, swset;
         clr   = (wr_go && word == RS_ACK) ? wmask : '0;
         swset = (wr_go && word == RS_STATUS && !lock_q) ? wmask : '0;
         status <= (status & ~clr) | hit | swset;
      end
   end

   // enable word: direct, set-only and clear-only views
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= '0;
      end else if (wr_go) begin
         case (word)
            RS_ENABLE: enable <= wmask;
            RS_SETEN:  enable <= enable | wmask;
            RS_CLREN:  enable <= enable & ~wmask;
            default:   enable <= enable;
         endcase
      end
   end

   // control: run is plain, lock is sticky until reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         lock_q <= 1'b0;
      end else if (wr_go && word == RS_CTRL) begin
         run_q  <= bus_wdata[CTRL_RUN_BIT];
         lock_q <= lock_q | bus_wdata[CTRL_LOCK_BIT];
      end
   end

   assign pend    = status & enable;
   assign irq_out = run_q & (|pend);

   irqc_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
      .pend (pend),
      .valid(vec_valid),
      .idx  (vec_idx)
   );

   always_comb begin
      stat_w = '0;
      pend_w = '0;
      en_w   = '0;
      vec_w  = '0;
      ctrl_w = '0;
      stat_w[NUM_SRC-1:0] = status;
      pend_w[NUM_SRC-1:0] = pend;
      en_w[NUM_SRC-1:0]   = enable;
      vec_w[IDX_W-1:0]    = vec_idx;
      if (!vec_valid) vec_w = '1;
      ctrl_w[CTRL_RUN_BIT]  = run_q;
      ctrl_w[CTRL_LOCK_BIT] = lock_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (word)
            RS_STATUS: bus_rdata = stat_w;
            RS_PEND:   bus_rdata = pend_w;
            RS_ENABLE: bus_rdata = en_w;
            RS_VECTOR: bus_rdata = vec_w;
            RS_CTRL:   bus_rdata = ctrl_w;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R3: written ones appear in the enable word
   a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && word == RS_SETEN) |=> ((enable & $past(wmask)) == $past(wmask)));

   // R4: written ones leave the enable word
   a_r4_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && word == RS_CLREN) |=> ((enable & $past(wmask)) == '0));

   // R5: acknowledged bits with no fresh request are gone
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && word == RS_ACK) |=> ((status & $past(wmask & ~hit)) == '0));

   // R6: the reported index is pending and nothing below it is
   a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (pend[vec_idx] &&
                     ((pend & ~({NUM_SRC{1'b1}} << vec_idx)) == '0)));

   // R8: a raised request always has a vector behind it
   a_r8_irq_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> vec_valid);

   // R11: lock never drops once set
   a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NS-1:0] src_in = '0;
   logic        irq_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_in(src_in), .irq_out(irq_out)
   );

   localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
      A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_CTRL = 5'h1C;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 status", A_STAT, 32'h0);
      rd_chk("R1 pending", A_PEND, 32'h0);
      rd_chk("R1 enable", A_EN, 32'h0);
      rd_chk("R1 vector", A_VEC, 32'hFFFF_FFFF);
      rd_chk("R1 ctrl", A_CTRL, 32'h0);
      chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_enable;
      wr(A_EN, 32'h0F);  rd_chk("R2 direct write", A_EN, 32'h0F);
      wr(A_SET, 32'h30); rd_chk("R3 set ones", A_EN, 32'h3F);
      wr(A_CLR, 32'h05); rd_chk("R4 clear ones", A_EN, 32'h3A);
      wr(A_EN, 32'hFFFF_FFFF); rd_chk("R12 upper enable bits", A_EN, 32'hFF);
      wr(A_EN, 32'h0);   rd_chk("R2 disable all", A_EN, 32'h0);
   endtask

   task automatic t_edge;
      wr(A_EN, 32'hFF);
      wr(A_CTRL, 32'h1);
      @(negedge clk) src_in[5] = 1'b1;
      @(negedge clk);
      rd_chk("R9 edge captured", A_STAT, 32'h20);
      rd_chk("R7 pending", A_PEND, 32'h20);
      rd_chk("R6 vector", A_VEC, 32'd5);
      chk("R8 irq raised", {31'h0, irq_out}, 32'h1);
      wr(A_ACK, 32'h20);
      rd_chk("R9 held edge stays clear", A_STAT, 32'h0);
      chk("R8 irq dropped", {31'h0, irq_out}, 32'h0);
      @(negedge clk) src_in[5] = 1'b0;
   endtask

   task automatic t_level;
      @(negedge clk) begin src_in[2] = 1'b1; src_in[6] = 1'b1; end
      @(negedge clk);
      rd_chk("R6 lowest index wins", A_VEC, 32'd2);
      wr(A_ACK, 32'hFFFF_FFFF);
      rd_chk("R10 level returns, R5 edge cleared", A_STAT, 32'h04);
      @(negedge clk) begin src_in[2] = 1'b0; src_in[6] = 1'b0; end
      wr(A_ACK, 32'hFFFF_FFFF);
      rd_chk("R5 all cleared", A_STAT, 32'h0);
      rd_chk("R6 nothing pending", A_VEC, 32'hFFFF_FFFF);
   endtask

   task automatic t_master;
      wr(A_CTRL, 32'h0);
      @(negedge clk) src_in[1] = 1'b1;
      @(negedge clk);
      chk("R8 run off blocks irq", {31'h0, irq_out}, 32'h0);
      rd_chk("R7 pending while run off", A_PEND, 32'h02);
      wr(A_CTRL, 32'h1);
      chk("R8 run on raises irq", {31'h0, irq_out}, 32'h1);
      wr(A_CLR, 32'h02);
      rd_chk("R7 disabled hides pending", A_PEND, 32'h0);
      rd_chk("R7 status kept", A_STAT, 32'h02);
      chk("R8 disabled drops irq", {31'h0, irq_out}, 32'h0);
      @(negedge clk) src_in[1] = 1'b0;
      wr(A_ACK, 32'h02);
      wr(A_SET, 32'h02);
   endtask

   task automatic t_swint;
      wr(A_STAT, 32'h80);
      rd_chk("R11 software set", A_STAT, 32'h80);
      wr(A_ACK, 32'h80);
      wr(A_CTRL, 32'h3);
      wr(A_STAT, 32'h01);
      rd_chk("R11 locked write ignored", A_STAT, 32'h0);
      wr(A_CTRL, 32'h0);
      rd_chk("R11 lock sticky", A_CTRL, 32'h2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_edge();
      t_level();
      t_master();
      t_swint();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule